// File: doc/BRIEF.md
# Multi-Analyzer Signature Diagnoser

This block splits response compaction for a circuit under test into several independent 16-bit multiple-input signature registers. Each output of the circuit under test is routed to exactly one analyzer by a fixed mapping parameter. Inside that analyzer, the output is XOR-folded into one input bit of the register.

A test session runs as follows:

1. Software loads a starting seed into every analyzer and stores one reference signature per analyzer.
2. The circuit's responses are streamed in under a valid strobe.
3. An end-of-session strobe closes the session.

At the end of the session the block compares every analyzer with its reference and builds a pass/fail codeword, with one bit per analyzer. It then narrows down the suspected faults using one fault-set mask per analyzer. A fault stays suspected only if every failing analyzer can observe it and no passing analyzer can observe it. Different nonzero codewords therefore name disjoint fault classes. The codeword and the suspected mask are registered and stay constant until the next seed load or end strobe.

The default build has twelve outputs, five analyzers and a 24-entry fault space. The analyzer count must lie between 2 and the output count; elaboration rejects other values.

Top module: `msa_diag`

## Requirements
- R1: While reset is asserted, and after it is released, `codeword` and `suspect` read zero.
- R2: On a clock edge with `seed_load` high, each analyzer `a` takes its seed from `seed_val[16*a +: 16]`. On the following cycle `codeword` and `suspect` read zero. `seed_load` has priority over `sess_end` in the same cycle.
- R3: On each edge with `resp_valid` high and `seed_load` low, every analyzer updates as next = (sig << 1) ^ (sig[15] ? 16'h100B : 0) ^ fold. Output k is XORed into `fold` bit (k mod 16) of analyzer `OUT_MAP[8*k +: 8]`; by default that analyzer is k mod `N_SA`.
- R4: On an edge with `sess_end` high and `seed_load` low, codeword bit i becomes 1 exactly when analyzer i's signature differs from reference i. The signature used is the one held before that edge, so a response presented in the same cycle is not counted.
- R5: A zero codeword gives a zero `suspect`.
- R6: For a nonzero codeword, `suspect` is the AND of the masks of the failing analyzers, with the OR of the masks of the passing analyzers cleared from it. Analyzer i's mask is `fault_mask[N_FAULT*i +: N_FAULT]`, sampled in the `sess_end` cycle.
- R7: Between end strobes and seed loads, `codeword` and `suspect` hold. Responses, reference loads and mask changes do not alter them.
- R8: `ref_load` stores `ref_val[16*a +: 16]` as reference a. References persist across seed loads and sessions until the next `ref_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Load all analyzer seeds and clear results |
| seed_val | input | 16*N_SA | Per-analyzer seeds |
| ref_load | input | 1 | Store reference signatures |
| ref_val | input | 16*N_SA | Per-analyzer references |
| resp_valid | input | 1 | Response vector valid |
| resp_data | input | N_OUT | Circuit-under-test output vector |
| sess_end | input | 1 | End-of-session strobe |
| fault_mask | input | N_FAULT*N_SA | Per-analyzer observable fault sets |
| codeword | output | N_SA | Failing-analyzer codeword |
| suspect | output | N_FAULT | Suspected fault class |

## Verification
The checker tests, on every clock cycle:
- clearing after a seed load, including its priority over the end strobe;
- the zero-codeword case giving an empty suspect mask;
- the holding of results between strobes;
- the class rule: suspect bits lie inside every failing analyzer's mask and outside every passing analyzer's mask, as sampled at the end strobe.

Only the bench scenarios can show the following:
- that the signature arithmetic and output routing produce the right codeword for each of the 32 failure patterns;
- that a response arriving together with the end strobe is excluded;
- that references survive reseeding.

// File: rtl/msa_pkg.sv
package msa_pkg;
  localparam int unsigned SIG_W   = 16;
  localparam logic [SIG_W-1:0] FB_POLY = 16'h100B;
  localparam int unsigned MAP_W   = 8;
  localparam int unsigned MAX_OUT = 128;

  // Output k feeds analyzer k mod n_sa.
  function automatic logic [MAP_W*MAX_OUT-1:0] rr_map(input int unsigned n_sa);
    logic [MAP_W*MAX_OUT-1:0] m;
    m = '0;
    for (int k = 0; k < MAX_OUT; k++) begin
      m[k*MAP_W +: MAP_W] = MAP_W'(k % n_sa);
    end
    return m;
  endfunction
endpackage

// File: rtl/msa_fold.sv
module msa_fold #(
  parameter int unsigned N_OUT = 12,
  parameter int unsigned N_SA  = 5,
  parameter logic [msa_pkg::MAP_W*msa_pkg::MAX_OUT-1:0] OUT_MAP = msa_pkg::rr_map(5)
) (
  input  logic [N_OUT-1:0]                 resp,
  output logic [N_SA*msa_pkg::SIG_W-1:0]   fold
);
  localparam int unsigned SW = msa_pkg::SIG_W;
  localparam int unsigned MW = msa_pkg::MAP_W;

  for (genvar a = 0; a < N_SA; a++) begin : g_sa
    always_comb begin
      fold[a*SW +: SW] = '0;
      for (int k = 0; k < N_OUT; k++) begin
        if (int'(OUT_MAP[k*MW +: MW]) == a) begin
          fold[a*SW + (k % SW)] = fold[a*SW + (k % SW)] ^ resp[k];
        end
      end
    end
  end
endmodule

// File: rtl/msa_misr.sv
module msa_misr #(
  parameter int unsigned SIG_W = 16,
  parameter logic [SIG_W-1:0] POLY = 16'h100B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SIG_W-1:0] seed,
  input  logic             step,
  input  logic [SIG_W-1:0] din,
  output logic [SIG_W-1:0] sig
);
  logic [SIG_W-1:0] sig_q, sig_nxt;
  logic [SIG_W-1:0] fb;

  always_comb begin
    fb      = sig_q[SIG_W-1] ? POLY : '0;
    sig_nxt = sig_q;
    if (load) begin
      sig_nxt = seed;
    end else if (step) begin
      sig_nxt = {sig_q[SIG_W-2:0], 1'b0} ^ fb ^ din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q <= '0;
    end else if (load || step) begin
      sig_q <= sig_nxt;
    end
  end

  assign sig = sig_q;
endmodule

// File: rtl/msa_classify.sv
module msa_classify #(
  parameter int unsigned N_SA    = 5,
  parameter int unsigned N_FAULT = 24
) (
  input  logic [N_SA-1:0]         cw,
  input  logic [N_FAULT*N_SA-1:0] masks,
  output logic [N_FAULT-1:0]      cls
);
  logic [N_FAULT-1:0] and_acc, or_acc;

  always_comb begin
    and_acc = '1;
    or_acc  = '0;
    for (int i = 0; i < N_SA; i++) begin
      if (cw[i]) and_acc = and_acc & masks[i*N_FAULT +: N_FAULT];
      else       or_acc  = or_acc  | masks[i*N_FAULT +: N_FAULT];
    end
    cls = (|cw) ? (and_acc & ~or_acc) : '0;
  end
endmodule

// File: rtl/msa_diag.sv
module msa_diag #(
  parameter int unsigned N_OUT   = 12,
  parameter int unsigned N_SA    = 5,
  parameter int unsigned N_FAULT = 24,
  parameter logic [msa_pkg::MAP_W*msa_pkg::MAX_OUT-1:0] OUT_MAP = msa_pkg::rr_map(N_SA)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           seed_load,
  input  logic [N_SA*msa_pkg::SIG_W-1:0] seed_val,
  input  logic                           ref_load,
  input  logic [N_SA*msa_pkg::SIG_W-1:0] ref_val,
  input  logic                           resp_valid,
  input  logic [N_OUT-1:0]               resp_data,
  input  logic                           sess_end,
  input  logic [N_FAULT*N_SA-1:0]        fault_mask,
  output logic [N_SA-1:0]                codeword,
  output logic [N_FAULT-1:0]             suspect
);
  localparam int unsigned SW  = msa_pkg::SIG_W;
  localparam int unsigned SGW = N_SA * SW;

  if (N_SA < 2 || N_SA > N_OUT) begin : g_bad_cfg
    $error("analyzer count out of range");
  end

  logic [SGW-1:0]     fold;
  logic [SGW-1:0]     sig_all;
  logic [SGW-1:0]     ref_q, ref_nxt;
  logic [N_SA-1:0]    mismatch;
  logic [N_FAULT-1:0] cls;
  logic [N_SA-1:0]    cw_q, cw_nxt;
  logic [N_FAULT-1:0] sus_q, sus_nxt;
  logic               step;

  assign step = resp_valid && !seed_load;

  msa_fold #(.N_OUT(N_OUT), .N_SA(N_SA), .OUT_MAP(OUT_MAP)) u_fold (
    .resp (resp_data),
    .fold (fold)
  );

  for (genvar a = 0; a < N_SA; a++) begin : g_an
    msa_misr #(.SIG_W(SW), .POLY(msa_pkg::FB_POLY)) u_misr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (seed_load),
      .seed  (seed_val[a*SW +: SW]),
      .step  (step),
      .din   (fold[a*SW +: SW]),
      .sig   (sig_all[a*SW +: SW])
    );
    assign mismatch[a] = (sig_all[a*SW +: SW] != ref_q[a*SW +: SW]);
  end

  msa_classify #(.N_SA(N_SA), .N_FAULT(N_FAULT)) u_cls (
    .cw    (mismatch),
    .masks (fault_mask),
    .cls   (cls)
  );

  always_comb begin
    ref_nxt = ref_load ? ref_val : ref_q;
    cw_nxt  = cw_q;
    sus_nxt = sus_q;
    if (seed_load) begin
      cw_nxt  = '0;
      sus_nxt = '0;
    end else if (sess_end) begin
      cw_nxt  = mismatch;
      sus_nxt = cls;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
    end else if (ref_load) begin
      ref_q <= ref_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cw_q  <= '0;
      sus_q <= '0;
    end else if (seed_load || sess_end) begin
      cw_q  <= cw_nxt;
      sus_q <= sus_nxt;
    end
  end

  assign codeword = cw_q;
  assign suspect  = sus_q;
endmodule

// File: rtl/msa_diag_chk.sv
module msa_diag_chk #(
  parameter int unsigned N_SA    = 5,
  parameter int unsigned N_FAULT = 24
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    seed_load,
  input logic                    sess_end,
  input logic [N_FAULT*N_SA-1:0] fault_mask,
  input logic [N_SA-1:0]         codeword,
  input logic [N_FAULT-1:0]      suspect
);
  // R2: seed load clears results, even with a simultaneous end strobe
  a_r2_seed_clears: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> (codeword == '0 && suspect == '0));

  // R5: no failing analyzer means nothing suspected
  a_r5_zero_cw_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (codeword == '0) |-> (suspect == '0));

  // R7: results hold between strobes
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_load && !sess_end) |=> ($stable(codeword) && $stable(suspect)));

  for (genvar i = 0; i < N_SA; i++) begin : g_cls
    // R6: suspects lie within every failing analyzer's mask
    a_r6_fail_subset: assert property (@(posedge clk) disable iff (!rst_n)
      (sess_end && !seed_load) |=>
        (!codeword[i] || ((suspect & ~$past(fault_mask[i*N_FAULT +: N_FAULT])) == '0)));
    // R6: suspects lie outside every passing analyzer's mask
    a_r6_pass_excluded: assert property (@(posedge clk) disable iff (!rst_n)
      (sess_end && !seed_load) |=>
        (codeword[i] || ((suspect & $past(fault_mask[i*N_FAULT +: N_FAULT])) == '0)));
  end
endmodule

bind msa_diag msa_diag_chk #(.N_SA(N_SA), .N_FAULT(N_FAULT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .seed_load  (seed_load),
  .sess_end   (sess_end),
  .fault_mask (fault_mask),
  .codeword   (codeword),
  .suspect    (suspect)
);

// File: tb/sim_msa_diag.sv
module sim_msa_diag;
  localparam int NO = 12;
  localparam int NS = 5;
  localparam int NF = 24;
  localparam int SW = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              seed_load, ref_load, resp_valid, sess_end;
  logic [NS*SW-1:0]  seed_val, ref_val;
  logic [NO-1:0]     resp_data;
  logic [NF*NS-1:0]  fault_mask;
  logic [NS-1:0]     codeword;
  logic [NF-1:0]     suspect;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10ns clk = ~clk;

  msa_diag u0 (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_val(seed_val),
    .ref_load(ref_load), .ref_val(ref_val), .resp_valid(resp_valid),
    .resp_data(resp_data), .sess_end(sess_end), .fault_mask(fault_mask),
    .codeword(codeword), .suspect(suspect)
  );

  function automatic logic [31:0] hash(input logic [31:0] x);
    logic [31:0] h;
    h = x * 32'h9E3779B1;
    h = h ^ (h >> 15);
    h = h * 32'h85EBCA6B;
    return h ^ (h >> 13);
  endfunction

  function automatic logic [15:0] mstep(input logic [15:0] s, input logic [NO-1:0] d, input int a);
    logic [15:0] f;
    f = '0;
    for (int k = 0; k < NO; k++) if (k % NS == a) f[k % SW] = f[k % SW] ^ d[k];
    return {s[14:0], 1'b0} ^ (s[15] ? 16'h100B : 16'h0000) ^ f;
  endfunction

  function automatic logic [NF-1:0] expect_cls(input logic [NS-1:0] cw, input logic [NF*NS-1:0] m);
    logic [NF-1:0] r;
    r = '0;
    if (cw != '0) begin
      for (int f = 0; f < NF; f++) begin
        bit keep;
        keep = 1'b1;
        for (int i = 0; i < NS; i++) begin
          if (cw[i] && !m[i*NF + f]) keep = 1'b0;
          if (!cw[i] && m[i*NF + f]) keep = 1'b0;
        end
        r[f] = keep;
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One session: inject single-bit errors on output a (analyzer a) for each bit of tgt.
  task automatic session(input logic [NS-1:0] tgt, input int salt, input bit do_ref);
    logic [15:0] gold [NS];
    logic [NF*NS-1:0] m;
    logic [NS-1:0] cw_hold;
    logic [NF-1:0] sus_hold;
    logic [NF-1:0] exp_sus;
    int len;
    len = 3 + (salt % 5);
    for (int a = 0; a < NS; a++) begin
      gold[a] = hash(salt * 7 + a)[15:0];
      seed_val[a*SW +: SW] = gold[a];
    end
    for (int b = 0; b < len; b++) begin
      logic [NO-1:0] d;
      d = hash(salt * 131 + b)[NO-1:0];
      for (int a = 0; a < NS; a++) gold[a] = mstep(gold[a], d, a);
    end
    for (int i = 0; i < NS; i++) m[i*NF +: NF] = hash(salt * 3 + i + 1000)[NF-1:0] | hash(salt + i)[NF-1:0];
    @(negedge clk);
    seed_load = 1'b1;
    ref_load  = do_ref;
    for (int a = 0; a < NS; a++) ref_val[a*SW +: SW] = gold[a];
    @(negedge clk);
    seed_load = 1'b0;
    ref_load  = 1'b0;
    check("R2 clear codeword", 32'(codeword), 32'h0);
    check("R2 clear suspect", 32'(suspect), 32'h0);
    for (int b = 0; b < len; b++) begin
      logic [NO-1:0] d;
      d = hash(salt * 131 + b)[NO-1:0];
      if (b == 1) d = d ^ NO'(tgt);
      resp_valid = 1'b1;
      resp_data  = d;
      @(negedge clk);
    end
    // R4: response in the end-strobe cycle must not count
    resp_data  = NO'(5'h1F);
    sess_end   = 1'b1;
    fault_mask = m;
    @(negedge clk);
    sess_end   = 1'b0;
    resp_valid = 1'b0;
    exp_sus = expect_cls(tgt, m);
    check("R3 R4 codeword", 32'(codeword), 32'(tgt));
    check("R5 R6 suspect", 32'(suspect), 32'(exp_sus));
    cw_hold  = codeword;
    sus_hold = suspect;
    // R7: further stimulus without strobes leaves results alone
    resp_valid = 1'b1;
    resp_data  = '1;
    ref_load   = 1'b1;
    ref_val    = ~ref_val;
    fault_mask = ~m;
    @(negedge clk);
    resp_valid = 1'b0;
    ref_load   = 1'b0;
    @(negedge clk);
    check("R7 hold codeword", 32'(codeword), 32'(cw_hold));
    check("R7 hold suspect", 32'(suspect), 32'(sus_hold));
    // restore references to the golden values
    @(negedge clk);
    ref_load = 1'b1;
    ref_val  = ~ref_val;
    @(negedge clk);
    ref_load = 1'b0;
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    seed_load = 0; ref_load = 0; resp_valid = 0; sess_end = 0;
    seed_val = '0; ref_val = '0; resp_data = '0; fault_mask = '0;
    repeat (3) @(negedge clk);
    check("R1 reset codeword", 32'(codeword), 32'h0);
    check("R1 reset suspect", 32'(suspect), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release codeword", 32'(codeword), 32'h0);
    check("R1 after release suspect", 32'(suspect), 32'h0);

    // exhaustive sweep over every failure codeword
    for (int t = 0; t < (1 << NS); t++) session(NS'(t), t + 1, 1'b1);

    // R8: references survive a reseed without ref_load (same salt as last session)
    session('0, 1 << NS, 1'b0);

    // R2: seed load wins over a simultaneous end strobe
    session(5'b10110, 77, 1'b1);
    @(negedge clk);
    seed_load = 1'b1;
    sess_end  = 1'b1;
    @(negedge clk);
    seed_load = 1'b0;
    sess_end  = 1'b0;
    check("R2 priority codeword", 32'(codeword), 32'h0);
    check("R2 priority suspect", 32'(suspect), 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule